// File: doc/BRIEF.md
# Two-Request Banked Cache Access Arbiter

This block sits in front of a cache data array built from several single-ported SRAM banks and makes that array look like it has two request ports. Each cycle it can accept one request on each port. It works out which bank each request addresses and drives the bank control lines directly. Two requests that land on different banks go out together. Two requests that land on the same bank are split: one goes now, and the other waits one cycle in a small per-port holding slot.

The bank is picked in one of two ways. In plain mode the bank is the line number modulo the bank count. In hashed mode, low line-number bits above the bank field are XORed into it, so that strided patterns spread across the banks. A read returns its data one cycle after it reaches a bank, together with the tag the requester supplied. Because of this, a port whose request was stalled finishes visibly later than the other port.

Top module: `bnkarb_top`

## Requirements
- R1: During and right after reset both ready outputs are 1, no bank enable is asserted and no completion is valid.
- R2: With hash_mode=0 the target bank is addr[7:6], which is (addr/64) mod 4 for 64-byte lines and four banks. The word address sent to that bank is {addr[11:8], addr[5:2]}.
- R3: With hash_mode=1 the target bank is addr[7:6] XOR addr[9:8]. The bank word address is {addr[11:8], addr[5:2]}, the same as in plain mode.
- R4: Two requests in one cycle to different banks are both accepted in that cycle.
- R5: When two requests target one bank, only one is accepted. The other port's ready drops in the next cycle, and the held request is accepted in that same next cycle.
- R6: In a same-bank conflict port 0 is accepted, unless port 1 has a held request from the previous cycle; in that case port 1 is accepted.
- R7: While a port's ready is 0, whatever that port drives on its request inputs is ignored. Only the held request is sent to the bank, and no extra completion appears.
- R8: An accepted read produces exactly one completion on its own port, in the cycle after acceptance. The completion carries the requester's tag and the bank's read data.
- R9: Two same-cycle writes to one address are applied port 0 first, then port 1, so port 1's data is the value left in memory.
- R10: An accepted write produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_mode | input | 1 | 0 = plain interleave, 1 = XOR-hashed bank select |
| p0_req_valid | input | 1 | Port 0 request present |
| p0_req_addr | input | 12 | Port 0 byte address |
| p0_req_we | input | 1 | Port 0 write (1) or read (0) |
| p0_req_wdata | input | 32 | Port 0 write data |
| p0_req_tag | input | 4 | Port 0 requester tag |
| p0_ready | output | 1 | Port 0 can take a new request |
| p0_accept | output | 1 | A port 0 request reaches a bank this cycle |
| p0_cpl_valid | output | 1 | Port 0 read completion |
| p0_cpl_tag | output | 4 | Tag of the completing port 0 read |
| p0_cpl_data | output | 32 | Data of the completing port 0 read |
| p1_req_valid | input | 1 | Port 1 request present |
| p1_req_addr | input | 12 | Port 1 byte address |
| p1_req_we | input | 1 | Port 1 write (1) or read (0) |
| p1_req_wdata | input | 32 | Port 1 write data |
| p1_req_tag | input | 4 | Port 1 requester tag |
| p1_ready | output | 1 | Port 1 can take a new request |
| p1_accept | output | 1 | A port 1 request reaches a bank this cycle |
| p1_cpl_valid | output | 1 | Port 1 read completion |
| p1_cpl_tag | output | 4 | Tag of the completing port 1 read |
| p1_cpl_data | output | 32 | Data of the completing port 1 read |
| bank_en | output | 4 | Per-bank access enable |
| bank_we | output | 4 | Per-bank write enable |
| bank_addr | output | 32 | Per-bank word address, 8 bits per bank |
| bank_wdata | output | 32x4 = 128 | Per-bank write data, 32 bits per bank |
| bank_rdata | input | 128 | Per-bank read data, valid one cycle after a read enable |

## Verification
A holding slot that keeps stale state shows up at the ports one cycle after the conflict. The stalled port either keeps ready low for too long or issues the wrong address, and the bank address lines expose this in that same cycle. Errors in bank selection or the hash show up in the cycle of acceptance, as the wrong bank_en bit or a pair that is wrongly split or merged. Errors in the in-flight completion state show up one cycle later, as a missing, duplicated or mis-tagged completion, or as data from the wrong bank. The bench sweeps all sixteen bank pairings in both selection modes and adds directed sequences for the priority rule and for same-address writes.

// File: rtl/bnkarb_pkg.sv
package bnkarb_pkg;
    localparam int NUM_PORTS = 2;

    typedef enum logic {
        WIN_P0 = 1'b0,
        WIN_P1 = 1'b1
    } win_e;
endpackage

// File: rtl/bnkarb_map.sv
// Address to (bank, word-in-bank) translation, plain or XOR-hashed.
module bnkarb_map #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 64,
    parameter int NUM_BANKS  = 4,
    parameter int DATA_W     = 32,
    parameter int SEL_W      = $clog2(NUM_BANKS),
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int WB_W       = $clog2(DATA_W / 8),
    parameter int BANK_AW    = ADDR_W - SEL_W - WB_W
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               hash_i,
    output logic [SEL_W-1:0]   bank_o,
    output logic [BANK_AW-1:0] idx_o
);
    logic [SEL_W-1:0] raw_sel;
    logic [SEL_W-1:0] tag_low;
    logic             unused_byte_bits;

    assign unused_byte_bits = ^addr_i[WB_W-1:0];

    always_comb begin
        raw_sel = addr_i[OFF_W +: SEL_W];
        tag_low = addr_i[OFF_W+SEL_W +: SEL_W];
        bank_o  = hash_i ? (raw_sel ^ tag_low) : raw_sel;
        // Bank-select field dropped; line bits above it and the word offset kept.
        idx_o   = {addr_i[ADDR_W-1:OFF_W+SEL_W], addr_i[OFF_W-1:WB_W]};
    end
endmodule

// File: rtl/bnkarb_hold.sv
// Per-port one-entry holding slot for a request that lost bank arbitration.
module bnkarb_hold #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_we_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [TAG_W-1:0]  req_tag_i,
    input  logic              lose_i,
    output logic              ready_o,
    output logic              eff_valid_o,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic              eff_we_o,
    output logic [DATA_W-1:0] eff_wdata_o,
    output logic [TAG_W-1:0]  eff_tag_o
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    slot_t slot_q, slot_d, eff;

    always_comb begin
        if (slot_q.valid) begin
            eff = slot_q;
        end else begin
            eff.valid = req_valid_i;
            eff.addr  = req_addr_i;
            eff.we    = req_we_i;
            eff.wdata = req_wdata_i;
            eff.tag   = req_tag_i;
        end
        slot_d       = slot_q;
        slot_d.valid = 1'b0;
        if (lose_i) begin
            slot_d       = eff;
            slot_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign ready_o     = !slot_q.valid;
    assign eff_valid_o = eff.valid;
    assign eff_addr_o  = eff.addr;
    assign eff_we_o    = eff.we;
    assign eff_wdata_o = eff.wdata;
    assign eff_tag_o   = eff.tag;

    // R6: a request already waiting in the slot is never made to wait again.
    a_r6_held_never_loses: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.valid |-> !lose_i);

    // R5: a request that lost is presented again next cycle and goes out.
    a_r5_loser_issues_next: assert property (@(posedge clk) disable iff (!rst_n)
        lose_i |=> (eff_valid_o && !lose_i));
endmodule

// File: rtl/bnkarb_issue.sv
// Conflict detection, winner choice and per-bank control drive.
module bnkarb_issue
    import bnkarb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int BANK_AW   = 8,
    parameter int DATA_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0]                 valid_i,
    input  logic [NUM_PORTS-1:0][SEL_W-1:0]      bank_i,
    input  logic [NUM_PORTS-1:0][BANK_AW-1:0]    idx_i,
    input  logic [NUM_PORTS-1:0]                 we_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata_i,
    input  logic                                 p1_held_i,
    output logic [NUM_PORTS-1:0]                 grant_o,
    output logic [NUM_PORTS-1:0]                 lose_o,
    output logic [NUM_BANKS-1:0]                 bank_en_o,
    output logic [NUM_BANKS-1:0]                 bank_we_o,
    output logic [NUM_BANKS*BANK_AW-1:0]         bank_addr_o,
    output logic [NUM_BANKS*DATA_W-1:0]          bank_wdata_o
);
    logic conflict;
    win_e win;

    always_comb begin
        conflict   = valid_i[0] && valid_i[1] && (bank_i[0] == bank_i[1]);
        win        = p1_held_i ? WIN_P1 : WIN_P0;
        grant_o[0] = valid_i[0] && !(conflict && (win == WIN_P1));
        grant_o[1] = valid_i[1] && !(conflict && (win == WIN_P0));
        lose_o     = valid_i & ~grant_o;
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic hit0, hit1;
        assign hit0 = grant_o[0] && (bank_i[0] == SEL_W'(k));
        assign hit1 = grant_o[1] && (bank_i[1] == SEL_W'(k));
        assign bank_en_o[k] = hit0 || hit1;
        assign bank_we_o[k] = hit0 ? we_i[0] : (hit1 && we_i[1]);
        assign bank_addr_o[k*BANK_AW +: BANK_AW] =
            hit0 ? idx_i[0] : (hit1 ? idx_i[1] : '0);
        assign bank_wdata_o[k*DATA_W +: DATA_W] =
            hit0 ? wdata_i[0] : (hit1 ? wdata_i[1] : '0);

        // R5: a single-ported bank never sees two accesses in one cycle.
        a_r5_one_access_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit0 && hit1));
    end
endmodule

// File: rtl/bnkarb_cpl.sv
// Tracks reads in flight for one cycle and returns tag plus bank data.
module bnkarb_cpl
    import bnkarb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              issue_rd_i,
    input  logic [NUM_PORTS-1:0][SEL_W-1:0]   bank_i,
    input  logic [NUM_PORTS-1:0][TAG_W-1:0]   tag_i,
    input  logic [NUM_BANKS*DATA_W-1:0]       bank_rdata_i,
    output logic [NUM_PORTS-1:0]              cpl_valid_o,
    output logic [NUM_PORTS-1:0][TAG_W-1:0]   cpl_tag_o,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  cpl_data_o
);
    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] bank;
        logic [TAG_W-1:0] tag;
    } flight_t;

    flight_t [NUM_PORTS-1:0] fl_q, fl_d;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            fl_d[p].valid  = issue_rd_i[p];
            fl_d[p].bank   = bank_i[p];
            fl_d[p].tag    = tag_i[p];
            cpl_valid_o[p] = fl_q[p].valid;
            cpl_tag_o[p]   = fl_q[p].tag;
            cpl_data_o[p]  = bank_rdata_i[fl_q[p].bank*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end
endmodule

// File: rtl/bnkarb_top.sv
module bnkarb_top
    import bnkarb_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 4,
    localparam int SEL_W     = $clog2(NUM_BANKS),
    localparam int WB_W      = $clog2(DATA_W / 8),
    localparam int BANK_AW   = ADDR_W - SEL_W - WB_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hash_mode,
    input  logic                          p0_req_valid,
    input  logic [ADDR_W-1:0]             p0_req_addr,
    input  logic                          p0_req_we,
    input  logic [DATA_W-1:0]             p0_req_wdata,
    input  logic [TAG_W-1:0]              p0_req_tag,
    output logic                          p0_ready,
    output logic                          p0_accept,
    output logic                          p0_cpl_valid,
    output logic [TAG_W-1:0]              p0_cpl_tag,
    output logic [DATA_W-1:0]             p0_cpl_data,
    input  logic                          p1_req_valid,
    input  logic [ADDR_W-1:0]             p1_req_addr,
    input  logic                          p1_req_we,
    input  logic [DATA_W-1:0]             p1_req_wdata,
    input  logic [TAG_W-1:0]              p1_req_tag,
    output logic                          p1_ready,
    output logic                          p1_accept,
    output logic                          p1_cpl_valid,
    output logic [TAG_W-1:0]              p1_cpl_tag,
    output logic [DATA_W-1:0]             p1_cpl_data,
    output logic [NUM_BANKS-1:0]          bank_en,
    output logic [NUM_BANKS-1:0]          bank_we,
    output logic [NUM_BANKS*BANK_AW-1:0]  bank_addr,
    output logic [NUM_BANKS*DATA_W-1:0]   bank_wdata,
    input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata
);
    logic [NUM_PORTS-1:0]               req_valid_a, req_we_a;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]   req_addr_a;
    logic [NUM_PORTS-1:0][DATA_W-1:0]   req_wdata_a;
    logic [NUM_PORTS-1:0][TAG_W-1:0]    req_tag_a;

    logic [NUM_PORTS-1:0]               ready_a, lose_a, grant_a;
    logic [NUM_PORTS-1:0]               eff_valid, eff_we;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]   eff_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0]   eff_wdata;
    logic [NUM_PORTS-1:0][TAG_W-1:0]    eff_tag;
    logic [NUM_PORTS-1:0][SEL_W-1:0]    eff_bank;
    logic [NUM_PORTS-1:0][BANK_AW-1:0]  eff_idx;

    logic [NUM_PORTS-1:0]               cpl_valid_a;
    logic [NUM_PORTS-1:0][TAG_W-1:0]    cpl_tag_a;
    logic [NUM_PORTS-1:0][DATA_W-1:0]   cpl_data_a;

    assign req_valid_a    = {p1_req_valid, p0_req_valid};
    assign req_we_a       = {p1_req_we, p0_req_we};
    assign req_addr_a[0]  = p0_req_addr;
    assign req_addr_a[1]  = p1_req_addr;
    assign req_wdata_a[0] = p0_req_wdata;
    assign req_wdata_a[1] = p1_req_wdata;
    assign req_tag_a[0]   = p0_req_tag;
    assign req_tag_a[1]   = p1_req_tag;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        bnkarb_hold #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_hold (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid_i (req_valid_a[p]),
            .req_addr_i  (req_addr_a[p]),
            .req_we_i    (req_we_a[p]),
            .req_wdata_i (req_wdata_a[p]),
            .req_tag_i   (req_tag_a[p]),
            .lose_i      (lose_a[p]),
            .ready_o     (ready_a[p]),
            .eff_valid_o (eff_valid[p]),
            .eff_addr_o  (eff_addr[p]),
            .eff_we_o    (eff_we[p]),
            .eff_wdata_o (eff_wdata[p]),
            .eff_tag_o   (eff_tag[p])
        );

        bnkarb_map #(
            .ADDR_W     (ADDR_W),
            .LINE_BYTES (LINE_BYTES),
            .NUM_BANKS  (NUM_BANKS),
            .DATA_W     (DATA_W)
        ) u_map (
            .addr_i (eff_addr[p]),
            .hash_i (hash_mode),
            .bank_o (eff_bank[p]),
            .idx_o  (eff_idx[p])
        );
    end

    bnkarb_issue #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .BANK_AW   (BANK_AW),
        .DATA_W    (DATA_W)
    ) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (eff_valid),
        .bank_i       (eff_bank),
        .idx_i        (eff_idx),
        .we_i         (eff_we),
        .wdata_i      (eff_wdata),
        .p1_held_i    (!ready_a[1]),
        .grant_o      (grant_a),
        .lose_o       (lose_a),
        .bank_en_o    (bank_en),
        .bank_we_o    (bank_we),
        .bank_addr_o  (bank_addr),
        .bank_wdata_o (bank_wdata)
    );

    bnkarb_cpl #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W)
    ) u_cpl (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_rd_i   (grant_a & ~eff_we),
        .bank_i       (eff_bank),
        .tag_i        (eff_tag),
        .bank_rdata_i (bank_rdata),
        .cpl_valid_o  (cpl_valid_a),
        .cpl_tag_o    (cpl_tag_a),
        .cpl_data_o   (cpl_data_a)
    );

    assign p0_ready     = ready_a[0];
    assign p1_ready     = ready_a[1];
    assign p0_accept    = grant_a[0];
    assign p1_accept    = grant_a[1];
    assign p0_cpl_valid = cpl_valid_a[0];
    assign p1_cpl_valid = cpl_valid_a[1];
    assign p0_cpl_tag   = cpl_tag_a[0];
    assign p1_cpl_tag   = cpl_tag_a[1];
    assign p0_cpl_data  = cpl_data_a[0];
    assign p1_cpl_data  = cpl_data_a[1];

    // R6: a stalled port 1 request goes out in the very next cycle.
    a_r6_stalled_p1_issues: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_ready |-> p1_accept);

    // R5: at most one port is ever waiting.
    a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(!p0_ready && !p1_ready));

    // R8: an accepted read completes on its port in the next cycle.
    a_r8_p0_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_accept && !eff_we[0]) |=> p0_cpl_valid);
    a_r8_p1_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_accept && !eff_we[1]) |=> p1_cpl_valid);

    // R10: an accepted write produces no completion.
    a_r10_p0_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_accept && eff_we[0]) |=> !p0_cpl_valid);
endmodule

// File: tb/bnkarb_top_tb_top.sv
`timescale 1ns/1ps
module bnkarb_top_tb_top;
    localparam int NB  = 4;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int TW  = 4;
    localparam int BAW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hash_mode = 1'b0;

    logic          p0_req_valid = 0, p1_req_valid = 0;
    logic [AW-1:0] p0_req_addr = '0, p1_req_addr = '0;
    logic          p0_req_we = 0, p1_req_we = 0;
    logic [DW-1:0] p0_req_wdata = '0, p1_req_wdata = '0;
    logic [TW-1:0] p0_req_tag = '0, p1_req_tag = '0;

    logic          p0_ready, p1_ready, p0_accept, p1_accept;
    logic          p0_cpl_valid, p1_cpl_valid;
    logic [TW-1:0] p0_cpl_tag, p1_cpl_tag;
    logic [DW-1:0] p0_cpl_data, p1_cpl_data;
    logic [NB-1:0] bank_en, bank_we;
    logic [NB*BAW-1:0] bank_addr;
    logic [NB*DW-1:0]  bank_wdata;
    logic [NB*DW-1:0]  bank_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bnkarb_top dut_i (
        .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode),
        .p0_req_valid(p0_req_valid), .p0_req_addr(p0_req_addr), .p0_req_we(p0_req_we),
        .p0_req_wdata(p0_req_wdata), .p0_req_tag(p0_req_tag), .p0_ready(p0_ready),
        .p0_accept(p0_accept), .p0_cpl_valid(p0_cpl_valid), .p0_cpl_tag(p0_cpl_tag),
        .p0_cpl_data(p0_cpl_data),
        .p1_req_valid(p1_req_valid), .p1_req_addr(p1_req_addr), .p1_req_we(p1_req_we),
        .p1_req_wdata(p1_req_wdata), .p1_req_tag(p1_req_tag), .p1_ready(p1_ready),
        .p1_accept(p1_accept), .p1_cpl_valid(p1_cpl_valid), .p1_cpl_tag(p1_cpl_tag),
        .p1_cpl_data(p1_cpl_data),
        .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // Single-ported bank storage model.
    logic [DW-1:0] mem [NB][256];
    always @(posedge clk) begin
        for (int k = 0; k < NB; k++) begin
            if (bank_en[k]) begin
                if (bank_we[k]) mem[k][bank_addr[k*BAW +: BAW]] <= bank_wdata[k*DW +: DW];
                else bank_rdata[k*DW +: DW] <= mem[k][bank_addr[k*BAW +: BAW]];
            end
        end
    end

    function automatic logic [1:0] ebank(input logic [AW-1:0] a, input logic h);
        return a[7:6] ^ (h ? a[9:8] : 2'b00);
    endfunction
    function automatic logic [BAW-1:0] eidx(input logic [AW-1:0] a);
        return {a[11:8], a[5:2]};
    endfunction
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {4'h5, a, 4'hC, ~a};
    endfunction

    task automatic preload(input logic h);
        for (int w = 0; w < 1024; w++) begin
            logic [AW-1:0] a;
            a = AW'(w << 2);
            mem[ebank(a, h)][eidx(a)] = pat(a);
        end
    endtask

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drv0(input logic v, input logic [AW-1:0] a, input logic we,
                        input logic [DW-1:0] d, input logic [TW-1:0] t);
        p0_req_valid = v; p0_req_addr = a; p0_req_we = we; p0_req_wdata = d; p0_req_tag = t;
    endtask
    task automatic drv1(input logic v, input logic [AW-1:0] a, input logic we,
                        input logic [DW-1:0] d, input logic [TW-1:0] t);
        p1_req_valid = v; p1_req_addr = a; p1_req_we = we; p1_req_wdata = d; p1_req_tag = t;
    endtask

    task automatic run_pair(input logic h, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                            input logic [TW-1:0] t0, input logic [TW-1:0] t1);
        logic [1:0] b0, b1;
        logic conf;
        string rq;
        b0 = ebank(a0, h);
        b1 = ebank(a1, h);
        conf = (b0 == b1);
        rq = h ? "R3" : "R2";
        // Cycle T: both ports request.
        @(negedge clk);
        drv0(1, a0, 0, '0, t0);
        drv1(1, a1, 0, '0, t1);
        #1;
        chk("R6", "p0 accept", 64'(p0_accept), 64'd1);
        chk(conf ? "R5" : "R4", "p1 accept", 64'(p1_accept), 64'(!conf));
        chk(rq, "bank en p0", 64'(bank_en[b0]), 64'd1);
        chk(rq, "bank addr p0", 64'(bank_addr[b0*BAW +: BAW]), 64'(eidx(a0)));
        if (!conf) begin
            chk(rq, "bank en p1", 64'(bank_en[b1]), 64'd1);
            chk(rq, "bank addr p1", 64'(bank_addr[b1*BAW +: BAW]), 64'(eidx(a1)));
        end
        // Cycle T+1.
        @(negedge clk);
        drv0(0, '0, 0, '0, '0);
        if (conf) drv1(1, 12'hFFC, 0, '0, 4'hF);   // R7: ignored while not ready
        else      drv1(0, '0, 0, '0, '0);
        #1;
        chk("R8", "p0 cpl valid", 64'(p0_cpl_valid), 64'd1);
        chk("R8", "p0 cpl tag", 64'(p0_cpl_tag), 64'(t0));
        chk("R8", "p0 cpl data", 64'(p0_cpl_data), 64'(pat(a0)));
        if (!conf) begin
            chk("R8", "p1 cpl valid", 64'(p1_cpl_valid), 64'd1);
            chk("R8", "p1 cpl tag", 64'(p1_cpl_tag), 64'(t1));
            chk("R8", "p1 cpl data", 64'(p1_cpl_data), 64'(pat(a1)));
        end else begin
            chk("R5", "p1 ready while held", 64'(p1_ready), 64'd0);
            chk("R5", "p1 held accept", 64'(p1_accept), 64'd1);
            chk("R7", "held addr not new", 64'(bank_addr[b1*BAW +: BAW]), 64'(eidx(a1)));
            chk("R8", "p1 no early cpl", 64'(p1_cpl_valid), 64'd0);
        end
        // Cycle T+2.
        @(negedge clk);
        drv1(0, '0, 0, '0, '0);
        #1;
        chk("R8", "p0 single cpl", 64'(p0_cpl_valid), 64'd0);
        if (conf) begin
            chk("R8", "p1 late cpl valid", 64'(p1_cpl_valid), 64'd1);
            chk("R8", "p1 late cpl tag", 64'(p1_cpl_tag), 64'(t1));
            chk("R8", "p1 late cpl data", 64'(p1_cpl_data), 64'(pat(a1)));
            chk("R5", "p1 ready restored", 64'(p1_ready), 64'd1);
        end else begin
            chk("R8", "p1 single cpl", 64'(p1_cpl_valid), 64'd0);
        end
        // Cycle T+3.
        @(negedge clk);
        #1;
        chk("R7", "no completion for ignored req", 64'(p1_cpl_valid), 64'd0);
        chk("R7", "banks idle", 64'(bank_en), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "p0 ready in reset", 64'(p0_ready), 64'd1);
        chk("R1", "p1 ready in reset", 64'(p1_ready), 64'd1);
        chk("R1", "bank en in reset", 64'(bank_en), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "cpl after reset", 64'({p0_cpl_valid, p1_cpl_valid}), 64'd0);
        chk("R1", "ready after reset", 64'({p0_ready, p1_ready}), 64'd3);

        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            hash_mode = h[0];
            preload(h[0]);
            for (int s0 = 0; s0 < 4; s0++) begin
                for (int s1 = 0; s1 < 4; s1++) begin
                    logic [1:0] u0, u1, sa, sb;
                    logic [3:0] w0, w1;
                    u0 = 2'(s0 + s1);
                    u1 = 2'(s0 + 3 * s1 + 1);
                    sa = 2'(s0);
                    sb = 2'(s1);
                    w0 = 4'(s0 * 4 + s1);
                    w1 = 4'(s1 * 4 + s0 + 1);
                    run_pair(h[0], {2'b00, u0, sa, w0, 2'b00}, {2'b01, u1, sb, w1, 2'b00},
                             4'(s0 + 1), 4'(s1 + 8));
                end
            end
        end

        // R6: a stalled port 1 beats a fresh port 0 request to the same bank.
        @(negedge clk);
        hash_mode = 1'b0;
        preload(1'b0);
        drv0(1, 12'h004, 0, '0, 4'd1);
        drv1(1, 12'h400, 0, '0, 4'd2);
        #1;
        chk("R6", "p0 wins fresh conflict", 64'({p0_accept, p1_accept}), 64'b10);
        @(negedge clk);
        drv0(1, 12'h008, 0, '0, 4'd3);
        drv1(0, '0, 0, '0, '0);
        #1;
        chk("R6", "held p1 wins", 64'({p0_accept, p1_accept}), 64'b01);
        chk("R6", "p0 ready before stall", 64'(p0_ready), 64'd1);
        chk("R8", "p0 first data", 64'(p0_cpl_data), 64'(pat(12'h004)));
        @(negedge clk);
        drv0(0, '0, 0, '0, '0);
        #1;
        chk("R5", "p0 ready low while held", 64'(p0_ready), 64'd0);
        chk("R5", "p0 held issues", 64'(p0_accept), 64'd1);
        chk("R8", "p1 cpl tag", 64'({p1_cpl_valid, p1_cpl_tag}), 64'({1'b1, 4'd2}));
        chk("R8", "p1 cpl data", 64'(p1_cpl_data), 64'(pat(12'h400)));
        @(negedge clk);
        #1;
        chk("R8", "p0 late cpl tag", 64'({p0_cpl_valid, p0_cpl_tag}), 64'({1'b1, 4'd3}));
        chk("R8", "p0 late cpl data", 64'(p0_cpl_data), 64'(pat(12'h008)));

        // R9/R10: two writes to the same address in one cycle.
        @(negedge clk);
        drv0(1, 12'h0C0, 1, 32'h1111_0000, 4'd4);
        drv1(1, 12'h0C0, 1, 32'h2222_0000, 4'd5);
        #1;
        chk("R9", "p0 write first", 64'({p0_accept, p1_accept}), 64'b10);
        chk("R9", "first write data", 64'(bank_wdata[3*DW +: DW]), 64'h1111_0000);
        chk("R9", "first write enable", 64'(bank_we[3]), 64'd1);
        @(negedge clk);
        drv0(0, '0, 0, '0, '0);
        drv1(0, '0, 0, '0, '0);
        #1;
        chk("R9", "p1 write second", 64'(p1_accept), 64'd1);
        chk("R9", "second write data", 64'(bank_wdata[3*DW +: DW]), 64'h2222_0000);
        chk("R10", "no cpl for p0 write", 64'(p0_cpl_valid), 64'd0);
        @(negedge clk);
        drv0(1, 12'h0C0, 0, '0, 4'd6);
        #1;
        chk("R10", "no cpl for p1 write", 64'(p1_cpl_valid), 64'd0);
        @(negedge clk);
        drv0(0, '0, 0, '0, '0);
        #1;
        chk("R9", "final value from port 1", 64'(p0_cpl_data), 64'h2222_0000);
        chk("R8", "readback tag", 64'(p0_cpl_tag), 64'd6);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule